// File: doc/BRIEF.md
# Debounced Power-Good Monitor

This block decides the state of a regulator's open-drain power-good pin from a few digital flags. Analog comparators elsewhere report three things. The first is whether the feedback voltage sits above the upper (rising) threshold. The second is whether it sits below the lower (falling) threshold. The third is whether the reference voltage is high enough to be valid. Three status inputs report shutdown, supply undervoltage lockout and thermal trip. A single-cycle tick, one per switching period, paces the qualification windows.

The output is a pull-down enable: 1 means the pin is driven low, and 0 means the pin is released to high impedance. A change in either direction happens only after the change's condition has held for a programmable number of ticks (48 by default). The two feedback thresholds differ, so between them the block holds its state. Any status condition drives the pin low at once and discards any qualification in progress.

Top module: `pgood_monitor`

## Requirements
- R1: While reset is asserted, and after it is released with no qualification completed, `pg_pull_low` is 1.
- R2: With `pg_pull_low` = 1 and no status input active, the output changes to 0 at the clock edge that samples the 48th tick (`cycle_tick` = 1). The release condition (`fb_over_rise` = 1, `fb_under_fall` = 0, `ref_ok` = 1) must have been true on every clock from the first of those ticks through that edge.
- R3: If the condition being qualified is false on any clock before the count completes, the count restarts from zero, and the output keeps its value.
- R4: With `pg_pull_low` = 0 and no status input active, the output changes to 1 once the fault condition (`fb_under_fall` = 1 or `ref_ok` = 0) has held over 48 ticks, under the same rules as R2.
- R5: With `fb_over_rise` = 0, `fb_under_fall` = 0 and `ref_ok` = 1, the output keeps its current value however many ticks pass.
- R6: `shutdown` = 1 drives `pg_pull_low` to 1 in the same cycle, with no clock edge needed.
- R7: `uvlo` = 1 (the supply is below the lockout threshold, given as an already-filtered flag) or `thermal_trip` = 1 drives `pg_pull_low` to 1 in the same cycle.
- R8: After all status inputs return to 0, the output stays 1 until a full R2 qualification has run, starting from zero after the release.
- R9: Clocks with `cycle_tick` = 0 do not advance a count. A lapse of the condition on such a clock still restarts the count.
- R10: If `fb_over_rise` and `fb_under_fall` are both 1, the input is treated as the fault condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | One-clock pulse per switching period |
| fb_over_rise | input | 1 | Feedback is above the rising threshold |
| fb_under_fall | input | 1 | Feedback is below the falling threshold |
| ref_ok | input | 1 | Reference is above its validity threshold |
| shutdown | input | 1 | Device is disabled |
| uvlo | input | 1 | Supply is below the lockout threshold |
| thermal_trip | input | 1 | Device is in thermal shutdown |
| pg_pull_low | output | 1 | 1 = power-good pin driven low, 0 = released |

## Verification
A count register that failed to clear on a lapse would release or drop the pin early. That shows at the port within one tick of the point where a correct count would still be short, so the tests hold conditions for 47 ticks, break them and hold them again. A state register that ignored the status inputs shows at once, because the output must go high in the same cycle and then stay high for 48 ticks after release. A wrong threshold decode shows as a transition while the flags sit between the thresholds, or as a release while both feedback flags are set.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;

  typedef enum logic {
    PG_LOW      = 1'b0,
    PG_RELEASED = 1'b1
  } pg_state_e;

  localparam int DIR_RISE = 0;
  localparam int DIR_FALL = 1;
  localparam int N_DIR    = 2;

  // release qualifies only on a clean, consistent "high" reading
  function automatic logic rise_ready(input logic above_rise,
                                      input logic below_fall,
                                      input logic ref_valid);
    return above_rise & ~below_fall & ref_valid;
  endfunction

  // any low reading or an invalid reference counts toward a drop
  function automatic logic fall_ready(input logic below_fall,
                                      input logic ref_valid);
    return below_fall | ~ref_valid;
  endfunction

  function automatic logic forced_low(input logic sd,
                                      input logic uv,
                                      input logic th);
    return sd | uv | th;
  endfunction

  function automatic int unsigned qual_width(input int unsigned ticks);
    return (ticks > 1) ? $clog2(ticks) : 1;
  endfunction

endpackage

// File: rtl/pgmon_cond.sv
module pgmon_cond
  import pgmon_pkg::*;
(
  input  logic above_rise,
  input  logic below_fall,
  input  logic ref_valid,
  input  logic sd,
  input  logic uv,
  input  logic th,
  output logic rise_cond,
  output logic fall_cond,
  output logic force_low
);

  always_comb begin
    rise_cond = rise_ready(above_rise, below_fall, ref_valid);
    fall_cond = fall_ready(below_fall, ref_valid);
    force_low = forced_low(sd, uv, th);
  end

endmodule

// File: rtl/pgmon_persist.sv
module pgmon_persist
  import pgmon_pkg::*;
#(
  parameter int unsigned LIMIT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cond,
  input  logic tick,
  output logic fire
);

  localparam int unsigned CNT_W = qual_width(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             at_last;

  assign run     = arm & cond;
  assign at_last = (cnt == LAST);
  assign fire    = run & tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || fire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST)
    else $error("count beyond qualification limit");

  assert_lapse_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0))
    else $error("count survived a lapse");

  assert_notick_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt))
    else $error("count moved without a tick");

endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
  import pgmon_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  input  logic fb_over_rise,
  input  logic fb_under_fall,
  input  logic ref_ok,
  input  logic shutdown,
  input  logic uvlo,
  input  logic thermal_trip,
  output logic pg_pull_low
);

  pg_state_e        st;
  logic             rise_w;
  logic             fall_w;
  logic             force_w;
  logic [N_DIR-1:0] cond_v;
  logic [N_DIR-1:0] arm_v;
  logic [N_DIR-1:0] fire_v;

  pgmon_cond u_cond (
    .above_rise (fb_over_rise),
    .below_fall (fb_under_fall),
    .ref_valid  (ref_ok),
    .sd         (shutdown),
    .uv         (uvlo),
    .th         (thermal_trip),
    .rise_cond  (rise_w),
    .fall_cond  (fall_w),
    .force_low  (force_w)
  );

  always_comb begin
    cond_v[DIR_RISE] = rise_w;
    cond_v[DIR_FALL] = fall_w;
    arm_v[DIR_RISE]  = (st == PG_LOW)      & ~force_w;
    arm_v[DIR_FALL]  = (st == PG_RELEASED) & ~force_w;
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    pgmon_persist #(.LIMIT(QUAL_TICKS)) u_persist (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (arm_v[d]),
      .cond  (cond_v[d]),
      .tick  (cycle_tick),
      .fire  (fire_v[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PG_LOW;
    end else if (force_w) begin
      st <= PG_LOW;
    end else if (fire_v[DIR_RISE]) begin
      st <= PG_RELEASED;
    end else if (fire_v[DIR_FALL]) begin
      st <= PG_LOW;
    end
  end

  assign pg_pull_low = force_w | (st == PG_LOW);

  assert_force_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_w |=> (st == PG_LOW))
    else $error("state not cleared by a status condition");

  assert_release_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PG_LOW) ##1 (st == PG_RELEASED) |-> $past(fire_v[DIR_RISE]))
    else $error("release without completed qualification");

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_w && fire_v == '0) |=> $stable(st))
    else $error("state moved with no qualifier firing");

  assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_v))
    else $error("both qualifiers fired together");

endmodule

// File: tb/sim_pgood_monitor.sv
module sim_pgood_monitor;

  localparam int QUAL = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hi = 1'b0, lo = 1'b0, rv = 1'b0;
  logic sd = 1'b0, uv = 1'b0, th = 1'b0;
  logic pull_low;

  int    n_vec = 0, n_bad = 0, cyc_count = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  bit m_good = 1'b0;
  int m_streak = 0;

  always #2.5 clk = ~clk;

  pgood_monitor #(.QUAL_TICKS(QUAL)) u0 (
    .clk(clk), .rst_n(rst_n), .cycle_tick(tick),
    .fb_over_rise(hi), .fb_under_fall(lo), .ref_ok(rv),
    .shutdown(sd), .uvlo(uv), .thermal_trip(th),
    .pg_pull_low(pull_low)
  );

  // behavioural reference: one streak counter of qualifying ticks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_good = 1'b0; m_streak = 0;
    end else if (sd || uv || th) begin
      m_good = 1'b0; m_streak = 0;
    end else begin
      bit want;
      if (m_good) want = lo || !rv;
      else        want = hi && !lo && rv;
      if (!want) m_streak = 0;
      else if (tick) begin
        m_streak = m_streak + 1;
        if (m_streak >= QUAL) begin m_good = !m_good; m_streak = 0; end
      end
    end
  end

  function automatic bit expected_out();
    return sd || uv || th || !m_good;
  endfunction

  task automatic check(input bit exp, input string tag);
    n_vec++;
    if (pull_low !== exp) begin
      n_bad++;
      $display("FAIL %s: pg_pull_low=%b expected %b at %0t", tag, pull_low, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) check(expected_out(), cur_req);

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cyc_count);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1 tick = 1'b0; end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(posedge clk); #1 tick = 1'b0;
      @(posedge clk); #1 tick = 1'b0;
      @(posedge clk); #1 tick = 1'b1;
    end
    @(posedge clk); #1 tick = 1'b0;
  endtask

  task automatic flags(input bit h, input bit l, input bit r);
    @(posedge clk); #1 hi = h; lo = l; rv = r; tick = 1'b0;
  endtask

  task automatic probe(input bit exp, input string tag);
    @(negedge clk); check(exp, tag);
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    probe(1'b1, "R1");
    @(posedge clk); #1 rst_n = 1'b1;
    probe(1'b1, "R1");

    cur_req = "R3";
    flags(1, 0, 1); ticks(QUAL - 1); probe(1'b1, "R3");
    flags(0, 0, 1); idle(2);
    flags(1, 0, 1); ticks(QUAL - 1); probe(1'b1, "R3");
    cur_req = "R2";
    ticks(1); probe(1'b0, "R2");

    cur_req = "R5";
    flags(0, 0, 1); ticks(120); probe(1'b0, "R5");

    cur_req = "R4";
    flags(0, 1, 1); ticks(30);
    flags(0, 0, 1); idle(1);
    flags(0, 1, 1); ticks(QUAL - 1); probe(1'b0, "R3");
    ticks(1); probe(1'b1, "R4");
    flags(0, 0, 1); ticks(90); probe(1'b1, "R5");

    flags(1, 0, 1); ticks(QUAL); probe(1'b0, "R2");
    cur_req = "R4";
    flags(1, 0, 0); ticks(QUAL - 1); probe(1'b0, "R4");
    ticks(1); probe(1'b1, "R4");
    flags(1, 0, 1); ticks(QUAL); probe(1'b0, "R2");

    cur_req = "R9";
    flags(1, 1, 1); idle(200); probe(1'b0, "R9");
    ticks(40);
    flags(1, 0, 1); idle(1);
    flags(1, 1, 1); ticks(40); probe(1'b0, "R9");
    ticks(8); probe(1'b1, "R10");

    cur_req = "R10";
    flags(1, 0, 1); ticks(QUAL); probe(1'b0, "R2");
    flags(1, 1, 1); ticks(QUAL - 1); probe(1'b0, "R10");
    ticks(1); probe(1'b1, "R10");

    cur_req = "R6";
    flags(1, 0, 1); ticks(QUAL); probe(1'b0, "R2");
    @(posedge clk); #1 sd = 1'b1;
    probe(1'b1, "R6");
    cur_req = "R8";
    @(posedge clk); #1 sd = 1'b0;
    probe(1'b1, "R8");
    ticks(QUAL - 1); probe(1'b1, "R8");
    ticks(1); probe(1'b0, "R8");

    cur_req = "R7";
    @(posedge clk); #1 uv = 1'b1;
    probe(1'b1, "R7");
    @(posedge clk); #1 uv = 1'b0;
    ticks(QUAL); probe(1'b0, "R8");
    @(posedge clk); #1 th = 1'b1;
    probe(1'b1, "R7");
    @(posedge clk); #1 th = 1'b0;
    cur_req = "R8";
    ticks(30);
    @(posedge clk); #1 uv = 1'b1;
    @(posedge clk); #1 uv = 1'b0;
    ticks(QUAL - 1); probe(1'b1, "R8");
    ticks(1); probe(1'b0, "R8");

    cur_req = "R3";
    for (int i = 0; i < 6000; i++) begin
      int r;
      @(posedge clk); #1;
      r = $urandom_range(0, 199);
      if (r == 0) hi = ~hi;
      else if (r == 1) lo = ~lo;
      else if (r == 2) rv = ~rv;
      else if (r == 3) sd = ~sd;
      else if (r == 4) uv = ($urandom_range(0, 3) == 0);
      if (sd && $urandom_range(0, 7) == 0) sd = 1'b0;
      th = ($urandom_range(0, 999) == 0);
      tick = ($urandom_range(0, 1) == 1);
    end
    idle(2);
    finish_run();
  end

endmodule